// File: doc/BRIEF.md
# Message-Signalled Interrupt File Register Page

This block holds the interrupt state of one interrupt file page. Every interrupt identity carries a pending flag and an enable flag, stored as two separate bit arrays. A one-bit delivery switch and a priority threshold register sit beside them. A register port reads and modifies the arrays one word at a time, 32 or 64 bits wide, with a per-bit write mask, and always returns the value the word held before the access. A message port receives doorbell writes: a device writes an identity number to the first word of the page, and that identity becomes pending.

The complete arrays, the delivery switch and the threshold go out as plain vectors to a priority selector, which is a separate block. A small access state machine sequences the register port. It accepts a request only in `ST_IDLE`. A request it can honour takes the transition IDLE→ACCESS, where the write lands and the old value is captured. A request it must refuse takes IDLE→REJECT, where nothing changes. Both ACCESS→IDLE and REJECT→IDLE are unconditional and issue the one-cycle acknowledge.

Top module: `imf_regs`

## Requirements
- R1: After reset, every pending and enable bit, the delivery switch, the threshold, the doorbell error flag and the acknowledge are all zero.
- R2: A register request sampled while the machine is idle gets exactly one acknowledge pulse on the second rising edge after it, carrying read data and error. A request sampled while an access is in progress is ignored.
- R3: Selector 0 addresses the pending array and selector 1 the enable array. Bit k of word n maps to identity n·32+k. Only bits set in the mask take the write data, and the acknowledge returns the word's old value.
- R4: With the wide flag set, an even index n covers identities n·32 to n·32+63. An odd index is refused with the error flag set, read data zero and no state change.
- R5: An index at or past NUM_IDS/32 (narrow), or whose half is at or past NUM_IDS/64 (wide), is refused in the same way.
- R6: Identity 0 reads as zero in both arrays and ignores writes.
- R7: Selector 2 is the delivery switch, and only data bit 0 is kept. Selector 3 is the threshold, and only the low THR_W bits are kept. Both ignore the index and return their old value.
- R8: A doorbell write of 4 bytes at page offset 0 with a value v, where 0 < v < NUM_IDS, sets pending bit v on that edge. The values 0 and NUM_IDS or higher change nothing.
- R9: Aligned in-range doorbell writes at any other offset (offset 4 included) and all doorbell reads change no state and do not raise the error flag. Read data is always zero.
- R10: A doorbell access with address bits [1:0] nonzero, a size code other than 2 (4 bytes), or a nonzero page number (address bits above 11) changes no state and sets the sticky error flag. Only reset clears that flag.
- R11: When a doorbell set and a register clear hit the same pending bit on the same edge, the bit ends up set.
- R12: The pending and enable vectors, the delivery switch and the threshold outputs always show the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_sel | input | 2 | 0 pending, 1 enable, 2 delivery, 3 threshold |
| reg_wide | input | 1 | 64-bit access when set |
| reg_idx | input | IDX_W | Word index for array accesses |
| reg_wdata | input | 64 | Write data |
| reg_wmask | input | 64 | Per-bit write mask |
| reg_ack | output | 1 | Access complete pulse |
| reg_err | output | 1 | Access refused, valid with reg_ack |
| reg_rdata | output | 64 | Old value, valid with reg_ack |
| msg_valid | input | 1 | Doorbell access strobe |
| msg_we | input | 1 | Doorbell write (1) or read (0) |
| msg_addr | input | AW | Byte address within the file window |
| msg_size | input | 2 | Log2 of access bytes |
| msg_wdata | input | 32 | Doorbell write value |
| msg_rdata | output | 32 | Doorbell read data, always zero |
| db_err | output | 1 | Sticky doorbell access error |
| pend_vec | output | NUM_IDS | Pending bits per identity |
| en_vec | output | NUM_IDS | Enable bits per identity |
| deliver_en | output | 1 | Delivery switch |
| threshold | output | THR_W | Priority threshold |

## Verification
The bench builds the block with NUM_IDS=128 and AW=16. With that size the narrow limit (index 4) and the wide limit (index 4, halved to 2) are one step past the last valid word, so both refusals and the topmost identity 127 can be reached. The doorbell value 128 lands exactly on the first out-of-range identity, and the 16-bit address reaches page 1, so the out-of-page error can be exercised. The threshold keeps its 11-bit default, so a full-ones write reads back as 0x7FF.

// File: rtl/imf_pkg.sv
package imf_pkg;

    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_EN    = 2'd1,
        SEL_DELIV = 2'd2,
        SEL_THR   = 2'd3
    } imf_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_REJECT = 2'd2
    } imf_state_e;

    localparam int unsigned IMF_LANE   = 32;
    localparam int unsigned IMF_DWORD  = 64;
    localparam int unsigned IMF_PAGE_B = 12;

endpackage

// File: rtl/imf_idx_check.sv
module imf_idx_check
    import imf_pkg::*;
#(
    parameter int unsigned NUM_IDS = 256,
    parameter int unsigned IDX_W   = 6
) (
    input  imf_sel_e         sel,
    input  logic             wide,
    input  logic [IDX_W-1:0] idx,
    output logic             ok
);
    localparam int unsigned NARROW_WORDS = NUM_IDS / IMF_LANE;
    localparam int unsigned WIDE_WORDS   = NUM_IDS / IMF_DWORD;
    localparam logic [IDX_W:0] NARROW_LIM = (IDX_W+1)'(NARROW_WORDS);
    localparam logic [IDX_W:0] WIDE_LIM   = (IDX_W+1)'(WIDE_WORDS);

    logic is_array;
    logic narrow_ok;
    logic wide_ok;

    always_comb begin
        is_array  = (sel == SEL_PEND) || (sel == SEL_EN);
        narrow_ok = ({1'b0, idx} < NARROW_LIM);
        wide_ok   = !idx[0] && ({2'b00, idx[IDX_W-1:1]} < WIDE_LIM);
        if (!is_array) begin
            ok = 1'b1;
        end else if (wide) begin
            ok = wide_ok;
        end else begin
            ok = narrow_ok;
        end
    end
endmodule

// File: rtl/imf_bit_array.sv
module imf_bit_array
    import imf_pkg::*;
#(
    parameter int unsigned NUM_IDS = 256,
    parameter int unsigned IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wide,
    input  logic [IDX_W-1:0]   idx,
    input  logic [63:0]        wdata,
    input  logic [63:0]        wmask,
    input  logic [NUM_IDS-1:0] set_vec,
    output logic [NUM_IDS-1:0] bits,
    output logic [63:0]        rdata
);
    localparam int unsigned SH_W = IDX_W + 5;

    // identity 0 owns no storage: it is permanently clear
    assign bits[0] = 1'b0;

    for (genvar i = 1; i < NUM_IDS; i++) begin : g_id
        localparam int unsigned WRD  = i / IMF_LANE;
        localparam int unsigned LANE = i % IMF_LANE;
        logic hit_lo;
        logic hit_hi;
        logic q;

        assign hit_lo = wr_en && (idx == IDX_W'(WRD));
        if (WRD >= 1) begin : g_hi
            assign hit_hi = wr_en && wide && (idx == IDX_W'(WRD - 1));
        end else begin : g_nohi
            assign hit_hi = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (set_vec[i]) begin
                q <= 1'b1;
            end else if (hit_lo && wmask[LANE]) begin
                q <= wdata[LANE];
            end else if (hit_hi && wmask[LANE+IMF_LANE]) begin
                q <= wdata[LANE+IMF_LANE];
            end
        end

        assign bits[i] = q;
    end

    logic [NUM_IDS-1:0] shifted;
    logic [SH_W-1:0]    shamt;

    always_comb begin
        shamt   = {idx, 5'b00000};
        shifted = bits >> shamt;
        rdata   = wide ? shifted[63:0] : {32'h0, shifted[31:0]};
    end
endmodule

// File: rtl/imf_doorbell.sv
module imf_doorbell
    import imf_pkg::*;
#(
    parameter int unsigned NUM_IDS = 256,
    parameter int unsigned AW      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic               msg_we,
    input  logic [AW-1:0]      msg_addr,
    input  logic [1:0]         msg_size,
    input  logic [31:0]        msg_wdata,
    output logic [NUM_IDS-1:0] set_vec,
    output logic               err_flag
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);
    localparam logic [31:0] ID_LIM = 32'(NUM_IDS);

    logic access_ok;
    logic le_slot;
    logic id_ok;
    logic fire;

    always_comb begin
        access_ok = (msg_addr[1:0] == 2'b00) && (msg_size == 2'd2)
                 && (msg_addr[AW-1:IMF_PAGE_B] == '0);
        le_slot   = (msg_addr[IMF_PAGE_B-1:0] == '0);
        id_ok     = (msg_wdata != 32'h0) && (msg_wdata < ID_LIM);
        fire      = msg_valid && msg_we && access_ok && le_slot && id_ok;
        set_vec   = '0;
        if (fire) begin
            set_vec[msg_wdata[ID_W-1:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (msg_valid && !access_ok) begin
            err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/imf_access_fsm.sv
module imf_access_fsm
    import imf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_ok,
    input  logic [63:0] rd_now,
    output imf_state_e  state,
    output logic        cap_en,
    output logic        do_write,
    output logic        ack,
    output logic        err,
    output logic [63:0] rdata
);
    imf_state_e state_q;
    imf_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = req_ok ? ST_ACCESS : ST_REJECT;
                end
            end
            ST_ACCESS: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state    = state_q;
    assign cap_en   = (state_q == ST_IDLE) && req;
    assign do_write = (state_q == ST_ACCESS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= (state_q == ST_ACCESS) || (state_q == ST_REJECT);
            err   <= (state_q == ST_REJECT);
            rdata <= (state_q == ST_ACCESS) ? rd_now : 64'h0;
        end
    end
endmodule

// File: rtl/imf_regs.sv
module imf_regs
    import imf_pkg::*;
#(
    parameter int unsigned NUM_IDS = 256,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned THR_W   = 11,
    parameter int unsigned AW      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wide,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [63:0]        reg_wdata,
    input  logic [63:0]        reg_wmask,
    output logic               reg_ack,
    output logic               reg_err,
    output logic [63:0]        reg_rdata,
    input  logic               msg_valid,
    input  logic               msg_we,
    input  logic [AW-1:0]      msg_addr,
    input  logic [1:0]         msg_size,
    input  logic [31:0]        msg_wdata,
    output logic [31:0]        msg_rdata,
    output logic               db_err,
    output logic [NUM_IDS-1:0] pend_vec,
    output logic [NUM_IDS-1:0] en_vec,
    output logic               deliver_en,
    output logic [THR_W-1:0]   threshold
);
    imf_sel_e         sel_in;
    imf_sel_e         cap_sel;
    logic             cap_wide;
    logic [IDX_W-1:0] cap_idx;
    logic [63:0]      cap_wdata;
    logic [63:0]      cap_wmask;
    logic             req_ok;
    imf_state_e       state;
    logic             cap_en;
    logic             do_write;
    logic             acc_idle;
    logic [63:0]      rd_now;
    logic [63:0]      pend_rd;
    logic [63:0]      en_rd;
    logic [NUM_IDS-1:0] db_set;

    assign sel_in   = imf_sel_e'(reg_sel);
    assign acc_idle = (state == ST_IDLE);
    assign msg_rdata = 32'h0;

    imf_idx_check #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) u_chk_idx (
        .sel  (sel_in),
        .wide (reg_wide),
        .idx  (reg_idx),
        .ok   (req_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_sel   <= SEL_PEND;
            cap_wide  <= 1'b0;
            cap_idx   <= '0;
            cap_wdata <= '0;
            cap_wmask <= '0;
        end else if (cap_en) begin
            cap_sel   <= sel_in;
            cap_wide  <= reg_wide;
            cap_idx   <= reg_idx;
            cap_wdata <= reg_wdata;
            cap_wmask <= reg_wmask;
        end
    end

    imf_doorbell #(.NUM_IDS(NUM_IDS), .AW(AW)) u_db (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_we    (msg_we),
        .msg_addr  (msg_addr),
        .msg_size  (msg_size),
        .msg_wdata (msg_wdata),
        .set_vec   (db_set),
        .err_flag  (db_err)
    );

    imf_bit_array #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_write && (cap_sel == SEL_PEND)),
        .wide    (cap_wide),
        .idx     (cap_idx),
        .wdata   (cap_wdata),
        .wmask   (cap_wmask),
        .set_vec (db_set),
        .bits    (pend_vec),
        .rdata   (pend_rd)
    );

    imf_bit_array #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_write && (cap_sel == SEL_EN)),
        .wide    (cap_wide),
        .idx     (cap_idx),
        .wdata   (cap_wdata),
        .wmask   (cap_wmask),
        .set_vec ('0),
        .bits    (en_vec),
        .rdata   (en_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deliver_en <= 1'b0;
            threshold  <= '0;
        end else if (do_write) begin
            if (cap_sel == SEL_DELIV) begin
                deliver_en <= (deliver_en & ~cap_wmask[0]) | (cap_wdata[0] & cap_wmask[0]);
            end
            if (cap_sel == SEL_THR) begin
                threshold <= (threshold & ~cap_wmask[THR_W-1:0])
                           | (cap_wdata[THR_W-1:0] & cap_wmask[THR_W-1:0]);
            end
        end
    end

    always_comb begin
        unique case (cap_sel)
            SEL_PEND:  rd_now = pend_rd;
            SEL_EN:    rd_now = en_rd;
            SEL_DELIV: rd_now = {63'h0, deliver_en};
            SEL_THR:   rd_now = {{(64-THR_W){1'b0}}, threshold};
            default:   rd_now = 64'h0;
        endcase
    end

    imf_access_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (reg_req),
        .req_ok   (req_ok),
        .rd_now   (rd_now),
        .state    (state),
        .cap_en   (cap_en),
        .do_write (do_write),
        .ack      (reg_ack),
        .err      (reg_err),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/imf_regs_chk.sv
module imf_regs_chk
    import imf_pkg::*;
#(
    parameter int unsigned NUM_IDS = 256,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned AW      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_req,
    input logic [1:0]         reg_sel,
    input logic               reg_wide,
    input logic [IDX_W-1:0]   reg_idx,
    input logic               reg_ack,
    input logic               reg_err,
    input logic               msg_valid,
    input logic               msg_we,
    input logic [AW-1:0]      msg_addr,
    input logic [1:0]         msg_size,
    input logic [31:0]        msg_wdata,
    input logic               db_err,
    input logic [NUM_IDS-1:0] pend_vec,
    input logic [NUM_IDS-1:0] en_vec,
    input logic               acc_idle
);
    localparam int unsigned ID_W = $clog2(NUM_IDS);

    // R2
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |=> !reg_ack);

    // R4
    odd_wide_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idle && reg_req && reg_wide && reg_idx[0] && (reg_sel[1] == 1'b0))
        |=> ##1 (reg_ack && reg_err));

    // R3
    arrays_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_idle && !msg_valid) |=> ($stable(pend_vec) && $stable(en_vec)));

    // R8
    doorbell_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_we && (msg_addr == '0) && (msg_size == 2'd2)
         && (msg_wdata != 32'h0) && (msg_wdata < 32'(NUM_IDS)))
        |=> pend_vec[$past(msg_wdata[ID_W-1:0])]);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_err |=> db_err);

    // R10
    misalign_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_addr[1:0] != 2'b00)) |=> db_err);
endmodule

bind imf_regs imf_regs_chk #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W), .AW(AW)) u_regs_chk (.*);

// File: tb/sim_imf_regs.sv
`timescale 1ns/1ps
module sim_imf_regs;
    localparam int unsigned N  = 128;
    localparam int unsigned IW = 6;
    localparam int unsigned TW = 11;
    localparam int unsigned AW = 16;

    typedef struct packed {
        logic [1:0]  sel;
        logic        wide;
        logic [5:0]  idx;
        logic [63:0] wd;
        logic [63:0] wm;
        logic [63:0] rd;
        logic        er;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 6'd0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'h0, 1'b0},
        '{2'd0, 1'b0, 6'd0, 64'h0, 64'h0, 64'hFFFF_FFFE, 1'b0},
        '{2'd0, 1'b0, 6'd0, 64'h0, 64'hF0, 64'hFFFF_FFFE, 1'b0},
        '{2'd0, 1'b0, 6'd0, 64'h0, 64'h0, 64'hFFFF_FF0E, 1'b0},
        '{2'd1, 1'b1, 6'd2, 64'hA5A5_0000_0000_0003, {64{1'b1}}, 64'h0, 1'b0},
        '{2'd1, 1'b1, 6'd2, 64'h0, 64'h0, 64'hA5A5_0000_0000_0003, 1'b0},
        '{2'd1, 1'b0, 6'd3, 64'h0, 64'h0, 64'hA5A5_0000, 1'b0},
        '{2'd1, 1'b1, 6'd1, {64{1'b1}}, {64{1'b1}}, 64'h0, 1'b1},
        '{2'd1, 1'b0, 6'd4, {64{1'b1}}, {64{1'b1}}, 64'h0, 1'b1},
        '{2'd1, 1'b1, 6'd4, {64{1'b1}}, {64{1'b1}}, 64'h0, 1'b1},
        '{2'd2, 1'b0, 6'd0, 64'hFF, 64'hFF, 64'h0, 1'b0},
        '{2'd2, 1'b0, 6'd0, 64'h0, 64'h0, 64'h1, 1'b0},
        '{2'd3, 1'b0, 6'd0, 64'hFFFF, 64'hFFFF, 64'h0, 1'b0},
        '{2'd3, 1'b0, 6'd0, 64'h0, 64'h0, 64'h7FF, 1'b0},
        '{2'd1, 1'b1, 6'd0, 64'h1, 64'h1, 64'h0, 1'b0},
        '{2'd1, 1'b1, 6'd0, 64'h0, 64'h0, 64'h0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_req = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic reg_wide = 1'b0;
    logic [IW-1:0] reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_wmask = '0;
    logic reg_ack, reg_err;
    logic [63:0] reg_rdata;
    logic msg_valid = 1'b0;
    logic msg_we = 1'b0;
    logic [AW-1:0] msg_addr = '0;
    logic [1:0] msg_size = 2'd2;
    logic [31:0] msg_wdata = '0;
    logic [31:0] msg_rdata;
    logic db_err;
    logic [N-1:0] pend_vec, en_vec;
    logic deliver_en;
    logic [TW-1:0] threshold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    imf_regs #(.NUM_IDS(N), .IDX_W(IW), .THR_W(TW), .AW(AW)) u0 (.*);

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_acc(input logic [1:0] s, input logic w, input logic [IW-1:0] i,
                           input logic [63:0] d, input logic [63:0] m,
                           output logic [63:0] rd, output logic er, output logic ak);
        @(negedge clk);
        reg_req = 1'b1; reg_sel = s; reg_wide = w; reg_idx = i; reg_wdata = d; reg_wmask = m;
        @(negedge clk);
        reg_req = 1'b0;
        @(negedge clk);
        rd = reg_rdata; er = reg_err; ak = reg_ack;
    endtask

    task automatic db(input logic we, input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_we = we; msg_addr = a; msg_size = sz; msg_wdata = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    function automatic string tag_of(input int k);
        case (k)
            0, 2:    return "R3";
            1, 3:    return "R6";
            4, 5, 6: return "R4";
            7:       return "R4";
            8, 9:    return "R5";
            10, 11:  return "R7";
            12, 13:  return "R7";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic er, ak;
        logic [N-1:0] snap;
        logic [N-1:0] exp_en;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ack", 128'(reg_ack), 128'h0);
        check("R1 pend", 128'(pend_vec), 128'h0);
        check("R1 en", 128'(en_vec), 128'h0);
        check("R1 deliver/thr", 128'({deliver_en, threshold}), 128'h0);
        check("R1 db_err", 128'(db_err), 128'h0);

        for (int k = 0; k < NV; k++) begin
            reg_acc(TBL[k].sel, TBL[k].wide, TBL[k].idx[IW-1:0], TBL[k].wd, TBL[k].wm, rd, er, ak);
            check({tag_of(k), " ack"}, 128'(ak), 128'h1);
            check({tag_of(k), " rdata"}, 128'(rd), 128'(TBL[k].rd));
            check({tag_of(k), " err"}, 128'(er), 128'(TBL[k].er));
        end

        // R12 exported state after the table
        exp_en = (128'hA5A5 << 112) | (128'h3 << 64);
        check("R12 pend", 128'(pend_vec), 128'hFFFF_FF0E);
        check("R12 en", 128'(en_vec), 128'(exp_en));
        check("R12 deliver", 128'(deliver_en), 128'h1);
        check("R12 thr", 128'(threshold), 128'h7FF);

        // R2 single pulse, and a request during the access is ignored
        @(negedge clk);
        reg_req = 1'b1; reg_sel = 2'd3; reg_wide = 1'b0; reg_idx = '0;
        reg_wdata = 64'h5; reg_wmask = 64'h7FF;
        @(negedge clk);
        reg_wdata = 64'h9;
        @(negedge clk);
        reg_req = 1'b0;
        check("R2 ack", 128'(reg_ack), 128'h1);
        @(negedge clk);
        check("R2 ack low", 128'(reg_ack), 128'h0);
        check("R2 busy ignored", 128'(threshold), 128'h5);

        // R8 doorbell
        db(1'b1, 16'h0, 2'd2, 32'd40);
        check("R8 set 40", 128'(pend_vec[40]), 128'h1);
        db(1'b1, 16'h0, 2'd2, 32'd127);
        check("R8 set 127", 128'(pend_vec[127]), 128'h1);
        snap = pend_vec;
        db(1'b1, 16'h0, 2'd2, 32'd0);
        check("R8 zero value", 128'(pend_vec), 128'(snap));
        db(1'b1, 16'h0, 2'd2, 32'd128);
        check("R8 out of range value", 128'(pend_vec), 128'(snap));

        // R9 other offsets and reads
        db(1'b1, 16'h4, 2'd2, 32'd41);
        check("R9 offset 4", 128'(pend_vec), 128'(snap));
        db(1'b1, 16'h10, 2'd2, 32'd41);
        check("R9 offset 16", 128'(pend_vec), 128'(snap));
        @(negedge clk);
        msg_valid = 1'b1; msg_we = 1'b0; msg_addr = 16'h0; msg_size = 2'd2; msg_wdata = 32'd41;
        #1;
        check("R9 read data", 128'(msg_rdata), 128'h0);
        @(negedge clk);
        msg_valid = 1'b0;
        check("R9 read no change", 128'(pend_vec), 128'(snap));
        check("R9 no error", 128'(db_err), 128'h0);

        // R10 errors
        db(1'b1, 16'h1000, 2'd2, 32'd42);
        check("R10 page err", 128'(db_err), 128'h1);
        check("R10 page no change", 128'(pend_vec), 128'(snap));
        db(1'b1, 16'h2, 2'd2, 32'd42);
        check("R10 misaligned no change", 128'(pend_vec), 128'(snap));
        db(1'b1, 16'h0, 2'd1, 32'd42);
        check("R10 size no change", 128'(pend_vec), 128'(snap));
        db(1'b1, 16'h0, 2'd2, 32'd51);
        check("R10 sticky", 128'(db_err), 128'h1);
        db(1'b1, 16'h0, 2'd2, 32'd50);

        // R11 same-edge set beats register clear (ids 50, 51 -> word 1 bits 18, 19)
        @(negedge clk);
        reg_req = 1'b1; reg_sel = 2'd0; reg_wide = 1'b0; reg_idx = 6'd1;
        reg_wdata = 64'h0; reg_wmask = 64'h000C_0000;
        @(negedge clk);
        reg_req = 1'b0;
        msg_valid = 1'b1; msg_we = 1'b1; msg_addr = 16'h0; msg_size = 2'd2; msg_wdata = 32'd50;
        @(negedge clk);
        msg_valid = 1'b0;
        check("R11 rdata old", 128'(reg_rdata), 128'h000C_0100);
        check("R11 set wins", 128'(pend_vec[50]), 128'h1);
        check("R11 plain clear", 128'(pend_vec[51]), 128'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule